// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine (1.7 Handshake)

This block turns single register accesses on a simple host I/O bus into enhanced parallel port cycles on a peripheral cable, using the older 1.7 handshake. The host picks the address or data register, sets a direction bit and pulls its active-low read or write strobe. The engine first sets up the peripheral write line and the data bus drive. It then pulls the matching peripheral strobe low and holds it until the host lets go of its own strobe. While the peripheral holds its active-low wait line low, the engine drives the host ready output low so that the host cycle stretches.

The host strobes are asynchronous and pass through a two-stage synchronizer. A cycle timer starts when a peripheral strobe is asserted. If the peripheral is still holding wait low when the timer limit is reached, the engine forces ready high and sets a sticky timeout flag. The host clears that flag with a one-cycle clear pulse. On reads, the peripheral byte is captured for the host on every clock edge at which wait is seen high during the strobe.

None of the host or peripheral signals is a stream, so every pin is a plain level. The host applies back-pressure only by holding its strobe, and the peripheral applies it only through wait.

Top module: `epp17_bridge`

## Requirements
- R1: While `rst` is high, and after it falls until a cycle starts: both peripheral strobes high, `p_write_n` high, `pd_oe` low, `host_ready` high, `tmo_flag` low, `pd_out` and `host_rdata` zero.
- R2: Write cycle (`host_dir`=0). On the third rising edge after `host_wr_n` goes low, `p_write_n` goes low, `pd_oe` goes high and `pd_out` takes `host_wdata`. On the next edge the strobe goes low: `p_astb_n` when `host_sel`=1, `p_dstb_n` when `host_sel`=0.
- R3: Read cycle (`host_dir`=1). On the third rising edge after `host_rd_n` goes low, `p_write_n` goes high and `pd_oe` low. On the next edge the strobe picked by `host_sel` goes low.
- R4: `p_dstb_n` and `p_astb_n` are never low together.
- R5: `host_ready` is low exactly while a peripheral strobe is low, `p_wait_n` is low and the current cycle has not timed out.
- R6: A cycle ends on the edge after the synchronised host strobe is seen released, which is the third edge after the pin rises. The peripheral strobe then returns high, and a write also reloads `pd_out` from `host_wdata`.
- R7: During a read strobe, `host_rdata` takes `pd_in` at each rising edge where `p_wait_n` is high. At all other times it holds its value.
- R8: The timer limit is `CLK_MHZ*TMO_US` edges. If `p_wait_n` is low at the limit-th edge after the strobe edge, `host_ready` is forced high for the rest of the cycle and `tmo_flag` sets.
- R9: `tmo_flag` stays set until a clock edge with `tmo_clr` high. A new timeout on the same edge wins over the clear.
- R10: A host strobe that does not match `host_dir` (write with dir 1, or read with dir 0) is ignored. No peripheral output changes.
- R11: The direction and the register select are sampled when a cycle starts. Changes to them during the cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | 1 selects the address register, 0 the data register |
| host_dir | input | 1 | 0 allows writes, 1 allows reads |
| host_wdata | input | 8 | Host write byte |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| tmo_clr | input | 1 | Clears the timeout flag |
| host_rdata | output | 8 | Byte captured from the peripheral |
| host_ready | output | 1 | Low stretches the host cycle |
| tmo_flag | output | 1 | Sticky timeout flag |
| pd_out | output | 8 | Peripheral data bus, driven value |
| pd_in | input | 8 | Peripheral data bus, received value |
| pd_oe | output | 1 | Peripheral data bus output enable |
| p_write_n | output | 1 | Peripheral write line, low for writes |
| p_dstb_n | output | 1 | Data strobe, active low |
| p_astb_n | output | 1 | Address strobe, active low |
| p_wait_n | input | 1 | Peripheral wait, active low |

## Verification
A wrong phase shows up within one edge as a strobe that is early or late relative to `p_write_n` and `pd_oe`, or as both strobes low together. A bad timer count shows at the limit-th edge as `host_ready` staying low, or releasing early, while wait is still low. A stuck sticky flag shows right after the clear pulse. A lost capture shows at the next read cycle as a stale `host_rdata`. Because the reference model is compared on every clock, any of these is caught on the edge where it first differs.

// File: rtl/epp17_pkg.sv
package epp17_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_STROBE = 2'd2
  } phase_t;
endpackage

// File: rtl/epp17_sync.sv
module epp17_sync #(
  parameter int W = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Active-low inputs: idle value is all ones.
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '1;
        else if (g == 0) stage[g] <= d;
        else stage[g] <= stage[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/epp17_timer.sv
module epp17_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  input  logic wait_n,
  input  logic clr,
  output logic expired,
  output logic flag
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = run && !expired && (cnt == CW'(LIMIT - 1)) && !wait_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (run && !expired && cnt < CW'(LIMIT)) begin
      cnt <= cnt + 1'b1;
      if (hit) expired <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(run && !wait_n));
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(clr));
endmodule

// File: rtl/epp17_fsm.sv
module epp17_fsm
  import epp17_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_act,
  input  logic          rd_act,
  input  logic          dir,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pd_in,
  input  logic          wait_n,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  output logic          write_n,
  output logic          dstb_n,
  output logic          astb_n,
  output logic [DW-1:0] rdata,
  output logic          start,
  output logic          strobing
);
  phase_t phase;
  logic   rd_cyc;
  logic   sel_q;
  logic   host_held;

  assign start     = (phase == PH_SETUP);
  assign strobing  = (phase == PH_STROBE);
  assign host_held = rd_cyc ? rd_act : wr_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      rd_cyc  <= 1'b0;
      sel_q   <= 1'b0;
      pd_out  <= '0;
      pd_oe   <= 1'b0;
      write_n <= 1'b1;
      dstb_n  <= 1'b1;
      astb_n  <= 1'b1;
      rdata   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (wr_act && !dir) begin
            phase   <= PH_SETUP;
            rd_cyc  <= 1'b0;
            sel_q   <= sel;
            write_n <= 1'b0;
            pd_oe   <= 1'b1;
            pd_out  <= wdata;
          end else if (rd_act && dir) begin
            phase   <= PH_SETUP;
            rd_cyc  <= 1'b1;
            sel_q   <= sel;
            write_n <= 1'b1;
            pd_oe   <= 1'b0;
          end
        end
        PH_SETUP: begin
          phase  <= PH_STROBE;
          dstb_n <= sel_q;
          astb_n <= !sel_q;
        end
        PH_STROBE: begin
          if (rd_cyc && wait_n) rdata <= pd_in;
          if (!host_held) begin
            phase  <= PH_IDLE;
            dstb_n <= 1'b1;
            astb_n <= 1'b1;
            if (!rd_cyc) pd_out <= wdata;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !(!dstb_n && !astb_n));
  assert_write_setup_R2: assert property (@(posedge clk) disable iff (rst)
    (!dstb_n || !astb_n) && !write_n |-> pd_oe);
  assert_read_float_R3: assert property (@(posedge clk) disable iff (rst)
    (!dstb_n || !astb_n) && write_n |-> !pd_oe);
  assert_lines_settled_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(dstb_n) || $fell(astb_n)) |-> $stable(write_n) && $stable(pd_oe));
endmodule

// File: rtl/epp17_bridge.sv
module epp17_bridge #(
  parameter int DW = 8,
  parameter int CLK_MHZ = 100,
  parameter int TMO_US = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_sel,
  input  logic          host_dir,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_wr_n,
  input  logic          host_rd_n,
  input  logic          tmo_clr,
  output logic [DW-1:0] host_rdata,
  output logic          host_ready,
  output logic          tmo_flag,
  output logic [DW-1:0] pd_out,
  input  logic [DW-1:0] pd_in,
  output logic          pd_oe,
  output logic          p_write_n,
  output logic          p_dstb_n,
  output logic          p_astb_n,
  input  logic          p_wait_n
);
  localparam int LIMIT = CLK_MHZ * TMO_US;

  logic [1:0] strb_sync;
  logic       start;
  logic       strobing;
  logic       expired;

  epp17_sync #(.W(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({host_rd_n, host_wr_n}),
    .q   (strb_sync)
  );

  epp17_fsm #(.DW(DW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .wr_act   (!strb_sync[0]),
    .rd_act   (!strb_sync[1]),
    .dir      (host_dir),
    .sel      (host_sel),
    .wdata    (host_wdata),
    .pd_in    (pd_in),
    .wait_n   (p_wait_n),
    .pd_out   (pd_out),
    .pd_oe    (pd_oe),
    .write_n  (p_write_n),
    .dstb_n   (p_dstb_n),
    .astb_n   (p_astb_n),
    .rdata    (host_rdata),
    .start    (start),
    .strobing (strobing)
  );

  epp17_timer #(.LIMIT(LIMIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .run     (strobing),
    .wait_n  (p_wait_n),
    .clr     (tmo_clr),
    .expired (expired),
    .flag    (tmo_flag)
  );

  assign host_ready = !(strobing && !p_wait_n && !expired);

  assert_stretch_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !host_ready |-> (!p_dstb_n || !p_astb_n) && !p_wait_n);
endmodule

// File: tb/epp17_bridge_test.sv
module epp17_bridge_test;
  localparam int LIM = 8;

  logic clk = 0;
  logic rst = 1;
  logic host_sel = 0, host_dir = 0, host_wr_n = 1, host_rd_n = 1, tmo_clr = 0;
  logic [7:0] host_wdata = 0, pd_in = 0;
  logic p_wait_n = 1;
  logic [7:0] host_rdata, pd_out;
  logic host_ready, tmo_flag, pd_oe, p_write_n, p_dstb_n, p_astb_n;

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  epp17_bridge #(.DW(8), .CLK_MHZ(2), .TMO_US(4)) uut (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_dir(host_dir),
    .host_wdata(host_wdata), .host_wr_n(host_wr_n), .host_rd_n(host_rd_n),
    .tmo_clr(tmo_clr), .host_rdata(host_rdata), .host_ready(host_ready),
    .tmo_flag(tmo_flag), .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe),
    .p_write_n(p_write_n), .p_dstb_n(p_dstb_n), .p_astb_n(p_astb_n),
    .p_wait_n(p_wait_n)
  );

  // Behavioural reference: pipelines as queues, cycle progress as integers.
  bit wq[$], rq[$];
  int m_ph = 0;            // 0 none, 1 lines prepared, 2 strobing
  bit m_rd = 0, m_sel = 0, m_wn = 1, m_oe = 0, m_ds = 1, m_as = 1, m_exp = 0, m_flag = 0;
  bit [7:0] m_pd = 0, m_rdata = 0;
  int m_edges = 0;

  function automatic void m_reset();
    wq = '{1, 1}; rq = '{1, 1};
    m_ph = 0; m_wn = 1; m_oe = 0; m_ds = 1; m_as = 1; m_exp = 0; m_flag = 0;
    m_pd = 0; m_rdata = 0; m_edges = 0; m_rd = 0; m_sel = 0;
  endfunction

  initial m_reset();

  always @(posedge clk) begin
    bit w_on, r_on, hit;
    cyc++;
    if (rst) m_reset();
    else begin
      w_on = !wq[0]; r_on = !rq[0];
      void'(wq.pop_front()); void'(rq.pop_front());
      wq.push_back(host_wr_n); rq.push_back(host_rd_n);
      hit = 0;
      if (m_ph == 0) begin
        if (w_on && !host_dir) begin
          m_ph = 1; m_rd = 0; m_sel = host_sel; m_wn = 0; m_oe = 1; m_pd = host_wdata;
        end else if (r_on && host_dir) begin
          m_ph = 1; m_rd = 1; m_sel = host_sel; m_wn = 1; m_oe = 0;
        end
      end else if (m_ph == 1) begin
        m_ph = 2; m_ds = m_sel; m_as = !m_sel; m_edges = 0; m_exp = 0;
      end else begin
        if (m_rd && p_wait_n) m_rdata = pd_in;
        if (!m_exp && m_edges < LIM) begin
          m_edges++;
          if (m_edges == LIM && !p_wait_n) begin m_exp = 1; hit = 1; end
        end
        if (!(m_rd ? r_on : w_on)) begin
          m_ph = 0; m_ds = 1; m_as = 1;
          if (!m_rd) m_pd = host_wdata;
        end
      end
      if (hit) m_flag = 1;
      else if (tmo_clr) m_flag = 0;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // Compare everything shortly after every rising edge.
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      chk("R2/R3 dstb", {7'd0, p_dstb_n}, {7'd0, m_ds});
      chk("R2/R3 astb", {7'd0, p_astb_n}, {7'd0, m_as});
      chk("R2/R3 write line", {7'd0, p_write_n}, {7'd0, m_wn});
      chk("R2/R3 bus enable", {7'd0, pd_oe}, {7'd0, m_oe});
      chk("R2/R6 pd_out", pd_out, m_pd);
      chk("R5/R8 ready", {7'd0, host_ready}, {7'd0, !(m_ph == 2 && !p_wait_n && !m_exp)});
      chk("R8/R9 flag", {7'd0, tmo_flag}, {7'd0, m_flag});
      chk("R7 rdata", host_rdata, m_rdata);
      chk("R4 one strobe", {7'd0, (!p_dstb_n && !p_astb_n)}, 8'd0);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_cycle(input bit rd, input bit sel, input bit [7:0] d,
                           input int wlow, input bit [7:0] rbyte, input bit hold);
    int g;
    @(negedge clk);
    host_dir = rd; host_sel = sel; host_wdata = d; pd_in = 8'h00; p_wait_n = 0;
    if (rd) host_rd_n = 0; else host_wr_n = 0;
    g = 0;
    while (p_dstb_n && p_astb_n && g < 50) begin @(negedge clk); g++; end
    // R11: flip direction and select mid-cycle; must not matter
    host_dir = !rd; host_sel = !sel;
    for (int k = 0; k < wlow; k++) @(negedge clk);
    pd_in = rbyte;
    if (!hold) p_wait_n = 1;
    g = 0;
    while (!host_ready && g < 50) begin @(negedge clk); g++; end
    @(negedge clk);
    if (rd) host_rd_n = 1; else host_wr_n = 1;
    g = 0;
    while (!(p_dstb_n && p_astb_n) && g < 50) begin @(negedge clk); g++; end
    p_wait_n = 1;
    host_dir = rd;
    idle(2);
  endtask

  initial begin : watchdog
    wait (cyc > 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 strobes", {6'd0, p_dstb_n, p_astb_n}, 8'd3);
    chk("R1 write line/oe", {6'd0, p_write_n, pd_oe}, 8'd2);
    chk("R1 ready/flag", {6'd0, host_ready, tmo_flag}, 8'd2);
    chk("R1 data", pd_out | host_rdata, 8'd0);
    rst = 0;
    idle(2);
    bus_cycle(0, 0, 8'hA5, 2, 8'h00, 0);
    bus_cycle(0, 1, 8'h3C, 0, 8'h00, 0);
    bus_cycle(1, 0, 8'h00, 3, 8'h5A, 0);
    chk("R7 read data", host_rdata, 8'h5A);
    bus_cycle(1, 1, 8'h00, 1, 8'hC3, 0);
    chk("R7 read addr", host_rdata, 8'hC3);
    bus_cycle(0, 0, 8'h77, 20, 8'h00, 1);
    chk("R8 timeout flag", {7'd0, tmo_flag}, 8'd1);
    idle(3);
    chk("R9 flag sticky", {7'd0, tmo_flag}, 8'd1);
    tmo_clr = 1; @(negedge clk); tmo_clr = 0;
    chk("R9 flag cleared", {7'd0, tmo_flag}, 8'd0);
    // R10: write strobe with read direction is ignored
    host_dir = 1; host_wdata = 8'hEE; host_wr_n = 0;
    idle(8);
    chk("R10 no strobe", {6'd0, p_dstb_n, p_astb_n}, 8'd3);
    chk("R10 lines held", {6'd0, p_write_n, pd_oe}, 8'd1);
    chk("R10 bus held", pd_out, 8'h77);
    host_wr_n = 1; host_dir = 0; host_rd_n = 0;
    idle(8);
    chk("R10 read ignored", {6'd0, p_dstb_n, p_astb_n}, 8'd3);
    host_rd_n = 1;
    idle(4);
    bus_cycle(1, 0, 8'h00, 30, 8'h99, 1);
    chk("R8 read timeout", {7'd0, tmo_flag}, 8'd1);
    tmo_clr = 1; @(negedge clk); tmo_clr = 0;
    bus_cycle(0, 1, 8'h12, 0, 8'h00, 0);
    chk("R6 last byte", pd_out, 8'h12);
    idle(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule